// File: doc/BRIEF.md
# Interrupt Controller Error Status Unit

This unit gathers the error conditions that an interrupt controller detects into a hidden accumulator. Checksum and acceptance failures arrive as one-cycle strobes. The unit itself judges the vectors of sent messages, received messages and error-entry writes, and the register bus flags decode misses as a strobe. Software cannot see the accumulator directly. A write to the status register moves the accumulated bits into the visible status value and empties the accumulator. A later read then returns what was gathered up to that write.

The unit also holds an error vector-table entry with a mask bit (bit 16, set at reset) and an 8-bit vector (bits 7:0). An error event while the entry is unmasked raises an interrupt request carrying the entry's vector. The request is driven by a two-state machine:
- ST_QUIET: idle. It moves to ST_RAISE on the transition "fire", which is an error event while the mask that applies after this cycle's writes is clear.
- ST_RAISE: drives the request. It stays in ST_RAISE on "refire" (another unmasked event) and returns to ST_QUIET on "settle" (no unmasked event).

Vectors 0 to 15 are illegal. Register select 0 addresses the status register and select 1 addresses the error entry.

Top module: `err_status_unit`

## Requirements
- R1: After reset the status value reads 0, the error entry reads 0x0001_0000 (masked, vector 0), and the interrupt request is low.
- R2: Error events do not change the status value. It changes only on the clock edge of a status write (reg_wr=1, reg_sel=0), and the write data is ignored.
- R3: A status write loads the errors gathered before that write into the status value and clears the accumulator, so a second write with no new errors reads 0.
- R4: An error that arrives in the same cycle as a status write is not lost. It is absent from that write's result and appears at the following status write.
- R5: Status bit positions: bit 0 is the send checksum error, bit 1 the receive checksum error, bit 2 the send accept error, bit 3 the receive accept error, and bit 7 the illegal register address. Bit 4 and bits 31:8 always read 0.
- R6: A sent message whose vector is below 16 sets bit 5, and a received message whose vector is below 16 sets bit 6. Vectors of 16 and above set no bit.
- R7: A write to the error entry (reg_wr=1, reg_sel=1) stores only bit 16 (mask) and bits 7:0 (vector), and all other bits read 0. A written vector below 16 sets status bit 6 even when the written mask bit is 1.
- R8: An error event while the entry is unmasked drives irq_req high in the next cycle, with irq_vec equal to the entry's vector. For an entry write, the newly written entry applies.
- R9: While the entry's mask bit is set, irq_req stays low whatever errors occur.
- R10: One isolated event gives exactly one cycle of irq_req. Events in consecutive cycles keep irq_req high for the same number of consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_cksum_err | input | 1 | Send checksum error strobe |
| rx_cksum_err | input | 1 | Receive checksum error strobe |
| tx_accept_err | input | 1 | Send accept error strobe |
| rx_accept_err | input | 1 | Receive accept error strobe |
| tx_msg_valid | input | 1 | A message is being sent this cycle |
| tx_msg_vec | input | 8 | Vector of the sent message |
| rx_msg_valid | input | 1 | A message was received this cycle |
| rx_msg_vec | input | 8 | Vector of the received message |
| bad_addr | input | 1 | Register bus access hit no register |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects error entry |
| reg_wdata | input | 32 | Register write data |
| status_rdata | output | 32 | Visible error status value |
| entry_rdata | output | 32 | Error entry contents |
| irq_req | output | 1 | Error interrupt request |
| irq_vec | output | 8 | Vector of the error interrupt |

## Verification
The assertions check on every cycle that the status value holds still between status writes and that its unused bits stay zero. They also check that the entry keeps only its mask and vector fields, that a masked entry never requests, and that an unmasked strobe is always followed by a request carrying the entry's vector. The split between accumulator and visible value can only be shown by the bench's scenarios. These are the exact bit pattern after a mixed burst, the empty result of a repeated write, an error that coincides with a write and surfaces one write later, the vector legality boundary at 15 and 16, and the request lengths for isolated and back-to-back events.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int STAT_W = 8;

    localparam int B_TX_CKSUM  = 0;
    localparam int B_RX_CKSUM  = 1;
    localparam int B_TX_ACCEPT = 2;
    localparam int B_RX_ACCEPT = 3;
    localparam int B_TX_BADVEC = 5;
    localparam int B_RX_BADVEC = 6;
    localparam int B_BAD_ADDR  = 7;

    // bits of the status byte that carry an error; bit 4 is unused
    localparam logic [STAT_W-1:0] STAT_USED = 8'b1110_1111;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_RAISE = 1'b1
    } irq_state_t;

endpackage

// File: rtl/err_detect.sv
module err_detect
    import errstat_pkg::*;
#(
    parameter int VEC_W         = 8,
    parameter int ILLEGAL_LIMIT = 16
) (
    input  logic              tx_cksum_err,
    input  logic              rx_cksum_err,
    input  logic              tx_accept_err,
    input  logic              rx_accept_err,
    input  logic              tx_msg_valid,
    input  logic [VEC_W-1:0]  tx_msg_vec,
    input  logic              rx_msg_valid,
    input  logic [VEC_W-1:0]  rx_msg_vec,
    input  logic              bad_addr,
    input  logic              ent_wr,
    input  logic [VEC_W-1:0]  ent_vec,
    output logic [STAT_W-1:0] new_err,
    output logic              any_err
);
    localparam logic [VEC_W-1:0] LIMIT_V = VEC_W'(ILLEGAL_LIMIT);

    logic tx_bad, rx_bad, ent_bad;

    always_comb begin
        tx_bad  = tx_msg_valid && (tx_msg_vec < LIMIT_V);
        rx_bad  = rx_msg_valid && (rx_msg_vec < LIMIT_V);
        ent_bad = ent_wr && (ent_vec < LIMIT_V);

        new_err              = '0;
        new_err[B_TX_CKSUM]  = tx_cksum_err;
        new_err[B_RX_CKSUM]  = rx_cksum_err;
        new_err[B_TX_ACCEPT] = tx_accept_err;
        new_err[B_RX_ACCEPT] = rx_accept_err;
        new_err[B_TX_BADVEC] = tx_bad;
        new_err[B_RX_BADVEC] = rx_bad || ent_bad;
        new_err[B_BAD_ADDR]  = bad_addr;
        new_err              = new_err & STAT_USED;
        any_err              = |new_err;
    end
endmodule

// File: rtl/err_accum.sv
module err_accum
    import errstat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] new_err,
    input  logic              stat_wr,
    output logic [DATA_W-1:0] status_rdata
);
    logic [STAT_W-1:0] acc_q;
    logic [STAT_W-1:0] stat_q;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (STAT_USED[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc_q[i]  <= 1'b0;
                    stat_q[i] <= 1'b0;
                end else if (stat_wr) begin
                    stat_q[i] <= acc_q[i];
                    acc_q[i]  <= new_err[i];
                end else begin
                    acc_q[i]  <= acc_q[i] | new_err[i];
                end
            end
        end else begin : g_tied
            assign acc_q[i]  = 1'b0;
            assign stat_q[i] = 1'b0;
        end
    end

    always_comb begin
        status_rdata               = '0;
        status_rdata[STAT_W-1:0]   = stat_q;
    end
endmodule

// File: rtl/err_entry.sv
module err_entry #(
    parameter int DATA_W   = 32,
    parameter int VEC_W    = 8,
    parameter int MASK_POS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_wr,
    input  logic              wr_mask,
    input  logic [VEC_W-1:0]  wr_vec,
    output logic              mask_q,
    output logic              mask_next,
    output logic [VEC_W-1:0]  vec_q,
    output logic [DATA_W-1:0] entry_rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            vec_q  <= '0;
        end else if (ent_wr) begin
            mask_q <= wr_mask;
            vec_q  <= wr_vec;
        end
    end

    always_comb begin
        mask_next                = ent_wr ? wr_mask : mask_q;
        entry_rdata              = '0;
        entry_rdata[MASK_POS]    = mask_q;
        entry_rdata[VEC_W-1:0]   = vec_q;
    end
endmodule

// File: rtl/err_irq_fsm.sv
module err_irq_fsm
    import errstat_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_err,
    input  logic             mask_next,
    input  logic [VEC_W-1:0] vec_q,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    irq_state_t state_q, state_d;
    logic       fire;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        fire    = any_err && !mask_next;
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (fire)  state_d = ST_RAISE;   // fire
            ST_RAISE: if (!fire) state_d = ST_QUIET;   // settle (else refire)
            default:             state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        unique case (state_q)
            ST_QUIET: ;
            ST_RAISE: begin
                irq_req = 1'b1;
                irq_vec = vec_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
    import errstat_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int VEC_W         = 8,
    parameter int MASK_POS      = 16,
    parameter int ILLEGAL_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_cksum_err,
    input  logic              rx_cksum_err,
    input  logic              tx_accept_err,
    input  logic              rx_accept_err,
    input  logic              tx_msg_valid,
    input  logic [VEC_W-1:0]  tx_msg_vec,
    input  logic              rx_msg_valid,
    input  logic [VEC_W-1:0]  rx_msg_vec,
    input  logic              bad_addr,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] status_rdata,
    output logic [DATA_W-1:0] entry_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    logic              stat_wr, ent_wr;
    logic [STAT_W-1:0] new_err;
    logic              any_err;
    logic              mask_q, mask_next;
    logic [VEC_W-1:0]  vec_q;
    logic              unused_wdata;

    assign stat_wr      = reg_wr && !reg_sel;
    assign ent_wr       = reg_wr && reg_sel;
    assign unused_wdata = ^reg_wdata;

    err_detect #(.VEC_W(VEC_W), .ILLEGAL_LIMIT(ILLEGAL_LIMIT)) u_detect (
        .tx_cksum_err (tx_cksum_err),
        .rx_cksum_err (rx_cksum_err),
        .tx_accept_err(tx_accept_err),
        .rx_accept_err(rx_accept_err),
        .tx_msg_valid (tx_msg_valid),
        .tx_msg_vec   (tx_msg_vec),
        .rx_msg_valid (rx_msg_valid),
        .rx_msg_vec   (rx_msg_vec),
        .bad_addr     (bad_addr),
        .ent_wr       (ent_wr),
        .ent_vec      (reg_wdata[VEC_W-1:0]),
        .new_err      (new_err),
        .any_err      (any_err)
    );

    err_accum #(.DATA_W(DATA_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .new_err     (new_err),
        .stat_wr     (stat_wr),
        .status_rdata(status_rdata)
    );

    err_entry #(.DATA_W(DATA_W), .VEC_W(VEC_W), .MASK_POS(MASK_POS)) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_wr     (ent_wr),
        .wr_mask    (reg_wdata[MASK_POS]),
        .wr_vec     (reg_wdata[VEC_W-1:0]),
        .mask_q     (mask_q),
        .mask_next  (mask_next),
        .vec_q      (vec_q),
        .entry_rdata(entry_rdata)
    );

    err_irq_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_err  (any_err),
        .mask_next(mask_next),
        .vec_q    (vec_q),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec)
    );
endmodule

// File: rtl/err_status_checker.sv
module err_status_checker #(
    parameter int DATA_W   = 32,
    parameter int VEC_W    = 8,
    parameter int MASK_POS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_cksum_err,
    input logic              rx_cksum_err,
    input logic              tx_accept_err,
    input logic              rx_accept_err,
    input logic              tx_msg_valid,
    input logic              rx_msg_valid,
    input logic              bad_addr,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [DATA_W-1:0] status_rdata,
    input logic [DATA_W-1:0] entry_rdata,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec
);
    localparam logic [DATA_W-1:0] ENTRY_KEEP =
        (DATA_W'(1) << MASK_POS) | ((DATA_W'(1) << VEC_W) - DATA_W'(1));

    logic maybe_event;
    assign maybe_event = tx_cksum_err | rx_cksum_err | tx_accept_err | rx_accept_err |
                         tx_msg_valid | rx_msg_valid | bad_addr | (reg_wr & reg_sel);

    // R2: status only moves on a status write
    assert_status_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_sel) |=> $stable(status_rdata));

    // R5: bit 4 and bits above the status byte stay zero
    assert_status_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_rdata >> 8) == '0) && !status_rdata[4]);

    // R7: only mask and vector fields of the entry are kept
    assert_entry_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_rdata & ~ENTRY_KEEP) == '0);

    // R8: an unmasked strobe with no entry write gives a request next cycle
    assert_unmasked_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_addr && !reg_wr && !entry_rdata[MASK_POS]) |=> irq_req);

    // R8: the request carries the entry vector
    assert_req_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == entry_rdata[VEC_W-1:0]));

    // R9: a masked entry never requests
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !entry_rdata[MASK_POS]);

    // R10: every request cycle is caused by an event in the cycle before
    assert_req_caused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(maybe_event));
endmodule

bind err_status_unit err_status_checker #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .MASK_POS(MASK_POS)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_cksum_err (tx_cksum_err),
    .rx_cksum_err (rx_cksum_err),
    .tx_accept_err(tx_accept_err),
    .rx_accept_err(rx_accept_err),
    .tx_msg_valid (tx_msg_valid),
    .rx_msg_valid (rx_msg_valid),
    .bad_addr     (bad_addr),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .status_rdata (status_rdata),
    .entry_rdata  (entry_rdata),
    .irq_req      (irq_req),
    .irq_vec      (irq_vec)
);

// File: tb/err_status_unit_test.sv
`timescale 1ns/1ps
module err_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_cksum_err = 0, rx_cksum_err = 0, tx_accept_err = 0, rx_accept_err = 0;
    logic        tx_msg_valid = 0, rx_msg_valid = 0, bad_addr = 0;
    logic [7:0]  tx_msg_vec = 0, rx_msg_vec = 0;
    logic        reg_wr = 0, reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] status_rdata, entry_rdata;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    err_status_unit uut (
        .clk(clk), .rst_n(rst_n),
        .tx_cksum_err(tx_cksum_err), .rx_cksum_err(rx_cksum_err),
        .tx_accept_err(tx_accept_err), .rx_accept_err(rx_accept_err),
        .tx_msg_valid(tx_msg_valid), .tx_msg_vec(tx_msg_vec),
        .rx_msg_valid(rx_msg_valid), .rx_msg_vec(rx_msg_vec),
        .bad_addr(bad_addr), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .status_rdata(status_rdata),
        .entry_rdata(entry_rdata), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        tx_cksum_err = 0; rx_cksum_err = 0; tx_accept_err = 0; rx_accept_err = 0;
        tx_msg_valid = 0; rx_msg_valid = 0; bad_addr = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    endtask

    // hold the current inputs for one clock edge, then clear them
    task automatic apply();
        @(negedge clk);
        clear_inputs();
        #1;
    endtask

    task automatic stat_write(input logic [31:0] junk);
        reg_wr = 1; reg_sel = 0; reg_wdata = junk;
        apply();
    endtask

    task automatic entry_write(input logic [31:0] d);
        reg_wr = 1; reg_sel = 1; reg_wdata = d;
        apply();
    endtask

    task automatic t_reset();
        check("R1 status", status_rdata, 32'h0);
        check("R1 entry", entry_rdata, 32'h0001_0000);
        check("R1 irq", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_accumulate();
        tx_cksum_err = 1; apply();
        check("R2 hidden", status_rdata, 32'h0);
        check("R9 masked", {31'b0, irq_req}, 32'h0);
        rx_cksum_err = 1; apply();
        tx_accept_err = 1; apply();
        rx_accept_err = 1; bad_addr = 1; apply();
        check("R2 still hidden", status_rdata, 32'h0);
        stat_write(32'hFFFF_FFFF);
        check("R5 bit map", status_rdata, 32'h0000_008F);
        apply();
        check("R2 stable after write", status_rdata, 32'h0000_008F);
    endtask

    task automatic t_clear();
        stat_write(32'h0);
        check("R3 cleared", status_rdata, 32'h0);
    endtask

    task automatic t_same_cycle();
        rx_accept_err = 1; reg_wr = 1; reg_sel = 0; apply();
        check("R4 not in this write", status_rdata, 32'h0);
        stat_write(32'h0);
        check("R4 kept for next write", status_rdata, 32'h0000_0008);
    endtask

    task automatic t_vectors();
        tx_msg_valid = 1; tx_msg_vec = 8'h0F; rx_msg_valid = 1; rx_msg_vec = 8'h10; apply();
        stat_write(32'h0);
        check("R6 tx vec 15 / rx vec 16", status_rdata, 32'h0000_0020);
        tx_msg_valid = 1; tx_msg_vec = 8'h10; rx_msg_valid = 1; rx_msg_vec = 8'h00; apply();
        stat_write(32'h0);
        check("R6 rx vec 0 / tx vec 16", status_rdata, 32'h0000_0040);
        tx_msg_valid = 1; tx_msg_vec = 8'hFF; rx_msg_valid = 1; rx_msg_vec = 8'h80; apply();
        stat_write(32'h0);
        check("R6 legal vectors", status_rdata, 32'h0);
    endtask

    task automatic t_entry();
        entry_write(32'hABCF_FF00);
        check("R7 fields", entry_rdata, 32'h0001_0000);
        check("R9 masked no irq", {31'b0, irq_req}, 32'h0);
        stat_write(32'h0);
        check("R7 masked zero vector error", status_rdata, 32'h0000_0040);
        entry_write(32'h0000_0031);
        check("R7 unmasked entry", entry_rdata, 32'h0000_0031);
        stat_write(32'h0);
        check("R7 legal vector no error", status_rdata, 32'h0);
    endtask

    task automatic t_irq();
        bad_addr = 1; apply();
        check("R8 irq raised", {31'b0, irq_req}, 32'h1);
        check("R8 irq vector", {24'b0, irq_vec}, 32'h31);
        apply();
        check("R10 single pulse", {31'b0, irq_req}, 32'h0);
        tx_cksum_err = 1; apply();
        check("R10 burst cycle 1", {31'b0, irq_req}, 32'h1);
        rx_cksum_err = 1; apply();
        check("R10 burst cycle 2", {31'b0, irq_req}, 32'h1);
        apply();
        check("R10 burst end", {31'b0, irq_req}, 32'h0);
        entry_write(32'h0000_0005);
        check("R8 new entry applies", {31'b0, irq_req}, 32'h1);
        check("R8 new vector", {24'b0, irq_vec}, 32'h05);
        stat_write(32'h0);
        entry_write(32'h0001_0040);
        tx_accept_err = 1; apply();
        check("R9 masked after write", {31'b0, irq_req}, 32'h0);
        apply();
        check("R9 masked quiet", {31'b0, irq_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_accumulate();
        t_clear();
        t_same_cycle();
        t_vectors();
        t_entry();
        t_irq();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule